// File: doc/BRIEF.md
# Passive FPGA Configuration Loader

This block is the master side of a passive configuration link. It takes a bitstream from an upstream byte stream and clocks it into a downstream programmable device. A single start pulse, together with a mode and a total byte count, launches a load. The block then runs the whole sequence without further help: it holds the device's configuration-reset line low, waits a setup time, and clocks out the bytes one at a time. Before each byte it checks the device's status line. After the last byte it issues a trailing clock edge and reads the completion line.

Three transfer modes exist. Serial mode sends each byte bit by bit on one data line. Parallel mode puts the whole byte on an 8-bit bus. Secure parallel mode does the same as parallel mode but gives the device extra clock cycles per byte. Every timing value is a count of system clock cycles set by a parameter: the reset pulse width, the setup delay, the completion wait and the width of each clock phase. The outcome is reported on three flags (busy, success, error) and on a count of the bytes accepted.

Top module: `fpga_cfg_loader`

## Requirements
- R1: A start pulse whose byte count is zero, or whose mode code is 3, is rejected. On the next cycle `error_o` is 1, `busy_o` stays 0 and `ncfg_o` stays high. Mode codes are 0 for serial, 1 for parallel and 2 for secure parallel.
- R2: An accepted start drives `ncfg_o` low for exactly `RST_CYC` clock cycles.
- R3: `dclk_o` stays low while `ncfg_o` is low. The first rising edge of `dclk_o` comes no sooner than `SETUP_CYC` cycles after `ncfg_o` returns high.
- R4: Each data-carrying high phase of `dclk_o` lasts exactly `CLK_DIV` cycles, and `data_o` does not change while `dclk_o` is high.
- R5: In serial mode (code 0), each byte produces 8 rising edges on `dclk_o`. At these edges `data_o[0]` carries bit 0 first and bit 7 last, and `data_o[7:1]` is 0.
- R6: In parallel mode (code 1), each byte produces one rising edge on `dclk_o`, with the whole byte on `data_o`.
- R7: In secure parallel mode (code 2), each byte produces 4 rising edges on `dclk_o`, and the same byte stays on `data_o` for all four.
- R8: `s_ready_o` is high only while the block waits for the next byte and `nstatus_i` is high. Each byte is taken once, and `sent_count_o` counts the bytes taken.
- R9: If `nstatus_i` is low while the block waits for a byte, the load aborts. `error_o` goes to 1, `busy_o` falls, `dclk_o` stays low, the offered byte is not taken, and `sent_count_o` keeps the number of bytes already transferred.
- R10: After the last byte there is exactly one more rising edge on `dclk_o`. The line is then held high for `DONE_CYC` cycles, and `conf_done_i` is sampled. If it is 1, `success_o` is set. If it is 0, `error_o` is set.
- R11: `success_o` and `error_o` are never both 1, and each keeps its value until the next start pulse is taken. A start pulse that arrives while `busy_o` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a load |
| mode_i | input | 2 | Transfer mode: 0 serial, 1 parallel, 2 secure parallel |
| byte_count_i | input | CNT_W | Total number of bytes in the load |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte is valid |
| s_ready_o | output | 1 | Block takes the stream byte this cycle |
| busy_o | output | 1 | A load is in progress |
| success_o | output | 1 | Last load ended with the completion line high |
| error_o | output | 1 | Last request was rejected or the load failed |
| sent_count_o | output | CNT_W | Bytes taken in the current or last load |
| ncfg_o | output | 1 | Active-low configuration reset to the device |
| dclk_o | output | 1 | Configuration clock to the device |
| data_o | output | 8 | Configuration data; only bit 0 is used in serial mode |
| nstatus_i | input | 1 | Device status, high while the device is healthy |
| conf_done_i | input | 1 | Device reports that configuration is complete |

## Verification
Two events can fall in the same cycle. While the block waits for the next byte, the device can drop its status line just as the stream offers a byte. The bench provokes this: it lowers `nstatus_i` during the clock pulses of the first byte and queues the second byte, so both are present when the block reaches the byte-wait state. The result passes only if the abort wins. That means no handshake for the second byte, no further rising edge on `dclk_o`, a byte count of one and the error flag set. A second collision is a new start request that arrives in the middle of a load. It carries an invalid mode and a zero count, and it must leave the load and its flags untouched.

// File: rtl/cfgl_pkg.sv
// Shared types and constants for the configuration loader.
// Assumes an 8-bit configuration byte in every mode.
package cfgl_pkg;

    localparam int unsigned BYTE_W = 8;

    // Transfer mode codes as seen on mode_i
    typedef enum logic [1:0] {
        MODE_SER = 2'd0,
        MODE_PAR = 2'd1,
        MODE_SEC = 2'd2,
        MODE_BAD = 2'd3
    } cfg_mode_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_SETUP,
        ST_FETCH,
        ST_LO,
        ST_HI,
        ST_FIN_LO,
        ST_DONE_WAIT
    } cfg_state_e;

    // Clock pulses issued for one byte in each mode
    localparam int unsigned PULSES_SER = 8;
    localparam int unsigned PULSES_PAR = 1;
    localparam int unsigned PULSES_SEC = 4;

endpackage

// File: rtl/cfgl_delay.sv
// Down-counter shared by every timed interval of the loader.
// A load of value N makes done_o true during the Nth cycle that follows,
// so a state that waits for done_o lasts exactly N cycles (N >= 1).
module cfgl_delay #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         done_o
);

    logic [W-1:0] cnt_q;

    // Load a new interval or count the current one down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The interval ends when one cycle or less is left
    assign done_o = (cnt_q <= W'(1));

endmodule

// File: rtl/cfgl_byte_path.sv
// Holds the byte being sent and presents it on the device data bus.
// In serial mode the byte shifts right and only bit 0 of the bus is used.
// In the other modes the whole byte is held and shift requests are ignored.
module cfgl_byte_path
    import cfgl_pkg::*;
#(
    parameter int unsigned DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] byte_i,
    input  logic          serial_i,
    input  logic          shift_i,
    output logic [DW-1:0] data_o
);

    logic [DW-1:0] sh_q;
    logic          ser_q;

    // Capture a new byte, or move to the next serial bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            ser_q <= 1'b0;
        end else if (load_i) begin
            sh_q  <= byte_i;
            ser_q <= serial_i;
        end else if (shift_i && ser_q) begin
            sh_q  <= {1'b0, sh_q[DW-1:1]};
        end
    end

    // Build the bus: in serial mode only lane 0 carries data
    for (genvar g = 0; g < DW; g++) begin : g_lane
        if (g == 0) begin : g_lsb
            assign data_o[g] = sh_q[g];
        end else begin : g_upper
            assign data_o[g] = ser_q ? 1'b0 : sh_q[g];
        end
    end

endmodule

// File: rtl/fpga_cfg_loader.sv
// Sequencer for a passive configuration load of a downstream device.
// Order of a load: reset pulse, setup wait, then for each byte a status
// check, fetch and clock pulses, then one trailing edge and the completion check.
// Assumes start_i is one cycle long and all delays are at least one cycle.
module fpga_cfg_loader
    import cfgl_pkg::*;
#(
    parameter int unsigned CNT_W     = 24,
    parameter int unsigned CLK_DIV   = 4,
    parameter int unsigned RST_CYC   = 250,
    parameter int unsigned SETUP_CYC = 5000,
    parameter int unsigned DONE_CYC  = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [CNT_W-1:0]  byte_count_i,
    input  logic [7:0]        s_data_i,
    input  logic              s_valid_i,
    output logic              s_ready_o,
    output logic              busy_o,
    output logic              success_o,
    output logic              error_o,
    output logic [CNT_W-1:0]  sent_count_o,
    output logic              ncfg_o,
    output logic              dclk_o,
    output logic [7:0]        data_o,
    input  logic              nstatus_i,
    input  logic              conf_done_i
);

    localparam int unsigned MAX_A = (RST_CYC > SETUP_CYC) ? RST_CYC : SETUP_CYC;
    localparam int unsigned MAX_B = (DONE_CYC > CLK_DIV) ? DONE_CYC : CLK_DIV;
    localparam int unsigned MAX_V = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned TW    = $clog2(MAX_V + 1);
    localparam int unsigned PW    = 4;

    cfg_state_e       st_q, st_n;
    cfg_mode_e        mode_q;
    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] sent_q;
    logic [PW-1:0]    pulses_q;
    logic             ncfg_q, dclk_q, ok_q, err_q;

    logic             tmr_load, tmr_done;
    logic [TW-1:0]    tmr_val;
    logic             bp_load, bp_shift;
    logic             start_ok, take_start, abort_now, finish_now;

    // Pulse count for one byte in the latched mode
    function automatic logic [PW-1:0] pulses_for(input cfg_mode_e m);
        case (m)
            MODE_SER: pulses_for = PW'(PULSES_SER);
            MODE_SEC: pulses_for = PW'(PULSES_SEC);
            default:  pulses_for = PW'(PULSES_PAR);
        endcase
    endfunction

    cfgl_delay #(.W(TW)) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .done_o (tmr_done)
    );

    cfgl_byte_path #(.DW(BYTE_W)) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (bp_load),
        .byte_i   (s_data_i),
        .serial_i (mode_q == MODE_SER),
        .shift_i  (bp_shift),
        .data_o   (data_o)
    );

    // A request is usable when it names a real mode and a non-empty load
    assign start_ok   = (byte_count_i != '0) && (cfg_mode_e'(mode_i) != MODE_BAD);
    assign take_start = (st_q == ST_IDLE) && start_i;
    assign abort_now  = (st_q == ST_FETCH) && !nstatus_i;
    assign finish_now = (st_q == ST_DONE_WAIT) && tmr_done;

    // Next state, interval loads and byte-path controls
    always_comb begin
        st_n     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        bp_load  = 1'b0;
        bp_shift = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start_i && start_ok) begin
                    st_n     = ST_RST;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RST_CYC);
                end
            end
            ST_RST: begin
                if (tmr_done) begin
                    st_n     = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETUP_CYC);
                end
            end
            ST_SETUP: begin
                if (tmr_done) st_n = ST_FETCH;
            end
            ST_FETCH: begin
                if (!nstatus_i) begin
                    st_n = ST_IDLE;
                end else if (s_valid_i) begin
                    st_n     = ST_LO;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CLK_DIV);
                    bp_load  = 1'b1;
                end
            end
            ST_LO: begin
                if (tmr_done) begin
                    st_n     = ST_HI;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CLK_DIV);
                end
            end
            ST_HI: begin
                if (tmr_done) begin
                    if (pulses_q > PW'(1)) begin
                        st_n     = ST_LO;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(CLK_DIV);
                        bp_shift = 1'b1;
                    end else if (sent_q == total_q) begin
                        st_n     = ST_FIN_LO;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(CLK_DIV);
                    end else begin
                        st_n = ST_FETCH;
                    end
                end
            end
            ST_FIN_LO: begin
                if (tmr_done) begin
                    st_n     = ST_DONE_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(DONE_CYC);
                end
            end
            ST_DONE_WAIT: begin
                if (tmr_done) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State, device lines and per-load bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            mode_q   <= MODE_SER;
            total_q  <= '0;
            sent_q   <= '0;
            pulses_q <= '0;
            ncfg_q   <= 1'b1;
            dclk_q   <= 1'b0;
        end else begin
            st_q   <= st_n;
            ncfg_q <= (st_n != ST_RST);
            dclk_q <= (st_n == ST_HI) || (st_n == ST_DONE_WAIT);
            if (take_start && start_ok) begin
                mode_q  <= cfg_mode_e'(mode_i);
                total_q <= byte_count_i;
                sent_q  <= '0;
            end
            if (bp_load) begin
                sent_q   <= sent_q + 1'b1;
                pulses_q <= pulses_for(mode_q);
            end else if (st_q == ST_HI && tmr_done) begin
                pulses_q <= pulses_q - 1'b1;
            end
        end
    end

    // Result flags: cleared by a taken start, set by rejection, abort or the final check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q  <= 1'b0;
            err_q <= 1'b0;
        end else if (take_start) begin
            ok_q  <= 1'b0;
            err_q <= !start_ok;
        end else if (abort_now) begin
            ok_q  <= 1'b0;
            err_q <= 1'b1;
        end else if (finish_now) begin
            ok_q  <= conf_done_i;
            err_q <= !conf_done_i;
        end
    end

    assign s_ready_o    = (st_q == ST_FETCH) && nstatus_i;
    assign busy_o       = (st_q != ST_IDLE);
    assign success_o    = ok_q;
    assign error_o      = err_q;
    assign sent_count_o = sent_q;
    assign ncfg_o       = ncfg_q;
    assign dclk_o       = dclk_q;

endmodule

// File: rtl/fpga_cfg_loader_chk.sv
// Protocol checker for the configuration loader, bound to every instance.
// Observes ports only; assumes the synchronous active-low reset.
module fpga_cfg_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       s_ready_o,
    input logic       busy_o,
    input logic       success_o,
    input logic       error_o,
    input logic       ncfg_o,
    input logic       dclk_o,
    input logic [7:0] data_o,
    input logic       nstatus_i
);

    // R3
    dclk_quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ncfg_o |-> !dclk_o);

    // R4
    data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk_o && $past(dclk_o)) |-> $stable(data_o));

    // R8
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (nstatus_i && busy_o && !dclk_o && ncfg_o));

    // R9
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!dclk_o && ncfg_o && !s_ready_o));

    // R11
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(success_o && error_o));

    // R11
    flags_clear_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!success_o && !error_o));

endmodule

bind fpga_cfg_loader fpga_cfg_loader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_ready_o (s_ready_o),
    .busy_o    (busy_o),
    .success_o (success_o),
    .error_o   (error_o),
    .ncfg_o    (ncfg_o),
    .dclk_o    (dclk_o),
    .data_o    (data_o),
    .nstatus_i (nstatus_i)
);

// File: tb/fpga_cfg_loader_tb_top.sv
// Scoreboard bench: the load task queues the expected bus value for every
// data edge, and a monitor pops and compares at each rising DCLK edge.
module fpga_cfg_loader_tb_top;

    localparam int DIV   = 2;
    localparam int RSTC  = 10;
    localparam int SETC  = 20;
    localparam int DONEC = 15;
    localparam int CW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [CW-1:0] count = '0;
    logic [7:0]    s_data = '0;
    logic          s_valid = 1'b0;
    logic          s_ready, busy, success, error_f, ncfg, dclk, nstatus = 1'b1, conf_done = 1'b1;
    logic [CW-1:0] sent;
    logic [7:0]    data;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    logic [7:0] feed_q[$];
    logic [7:0] load_bytes[$];
    int final_rises = 0;
    int handshakes = 0;
    string data_req = "R6";
    bit mon_en = 1'b0;

    always #10 clk = ~clk;

    fpga_cfg_loader #(
        .CNT_W(CW), .CLK_DIV(DIV), .RST_CYC(RSTC), .SETUP_CYC(SETC), .DONE_CYC(DONEC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .byte_count_i(count),
        .s_data_i(s_data), .s_valid_i(s_valid), .s_ready_o(s_ready), .busy_o(busy),
        .success_o(success), .error_o(error_f), .sent_count_o(sent), .ncfg_o(ncfg),
        .dclk_o(dclk), .data_o(data), .nstatus_i(nstatus), .conf_done_i(conf_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Stream driver: offers queued bytes, pops one after each handshake edge
    initial begin
        bit pend;
        pend = 1'b0;
        forever begin
            @(negedge clk);
            #1;
            if (pend) begin
                void'(feed_q.pop_front());
                handshakes++;
            end
            s_valid = (feed_q.size() > 0);
            s_data  = (feed_q.size() > 0) ? feed_q[0] : 8'h00;
            pend    = s_valid && s_ready;
        end
    end

    // Monitor: scoreboard compare at DCLK rises, pulse widths and reset timing
    initial begin
        bit   dprev, nprev, is_final, first_pend;
        int   hw, lw, gap;
        logic [7:0] held;
        dprev = 1'b0; nprev = 1'b1; is_final = 1'b0; first_pend = 1'b0;
        hw = 0; lw = 0; gap = 0; held = '0;
        forever begin
            @(negedge clk);
            if (mon_en) begin
                if (dclk && !dprev) begin
                    if (first_pend) begin
                        check(gap >= SETC, "R3 setup gap", gap, SETC);
                        first_pend = 1'b0;
                    end
                    if (exp_q.size() > 0) begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        check(data == e, data_req, data, e);
                        is_final = 1'b0;
                    end else begin
                        final_rises++;
                        is_final = 1'b1;
                    end
                    hw = 1;
                    held = data;
                end else if (dclk) begin
                    hw++;
                    check(data == held, "R4 hold", data, held);
                end
                if (!dclk && dprev) begin
                    if (is_final) check(hw == DONEC, "R10 final width", hw, DONEC);
                    else          check(hw == DIV, "R4 high width", hw, DIV);
                end
                if (!ncfg) begin
                    lw++;
                    check(!dclk, "R3 dclk during reset", dclk, 0);
                end
                if (ncfg && !nprev) begin
                    check(lw == RSTC, "R2 reset width", lw, RSTC);
                    lw = 0;
                    gap = 0;
                    first_pend = 1'b1;
                end
                if (ncfg && first_pend && !dclk) gap++;
            end
            dprev = dclk;
            nprev = ncfg;
        end
    end

    task automatic pulse_start(input logic [1:0] m, input logic [CW-1:0] c);
        @(negedge clk);
        start = 1'b1; mode = m; count = c;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // One full load with the bytes in load_bytes; disturb adds an ignored start mid-load
    task automatic run_load(input logic [1:0] m, input bit cd, input bit disturb);
        string rq;
        rq = (m == 2'd0) ? "R5" : (m == 2'd1) ? "R6" : "R7";
        data_req = rq;
        conf_done = cd;
        final_rises = 0;
        handshakes = 0;
        foreach (load_bytes[k]) begin
            feed_q.push_back(load_bytes[k]);
            if (m == 2'd0) begin
                for (int b = 0; b < 8; b++) exp_q.push_back({7'b0, load_bytes[k][b]});
            end else if (m == 2'd1) begin
                exp_q.push_back(load_bytes[k]);
            end else begin
                for (int r = 0; r < 4; r++) exp_q.push_back(load_bytes[k]);
            end
        end
        pulse_start(m, CW'(load_bytes.size()));
        check(busy && !error_f && !success, "R11 flags cleared", {busy, error_f, success}, 3'b100);
        if (disturb) begin
            repeat (40) @(negedge clk);
            pulse_start(2'd3, '0);
            check(busy && !error_f, "R11 start ignored while busy", {busy, error_f}, 2'b10);
        end
        wait_idle();
        check(success == cd, "R10 success", success, cd);
        check(error_f == !cd, "R10 error", error_f, !cd);
        check(final_rises == 1, "R10 trailing edge", final_rises, 1);
        check(exp_q.size() == 0, rq, exp_q.size(), 0);
        check(sent == CW'(load_bytes.size()), "R8 byte count", sent, load_bytes.size());
        check(handshakes == load_bytes.size(), "R8 handshakes", handshakes, load_bytes.size());
        check(!dclk && ncfg, "R9 idle lines", {dclk, ncfg}, 2'b01);
        exp_q.delete();
        feed_q.delete();
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;
        check(!busy && !success && !error_f, "R11 reset flags", {busy, success, error_f}, 0);
        check(ncfg && !dclk && !s_ready, "R9 reset lines", {ncfg, dclk, s_ready}, 3'b100);

        // R1: zero count, then invalid mode
        pulse_start(2'd1, '0);
        check(error_f && !busy && ncfg, "R1 zero count", {error_f, busy, ncfg}, 3'b101);
        repeat (5) @(negedge clk);
        check(error_f && !busy, "R11 error held", {error_f, busy}, 2'b10);
        pulse_start(2'd3, CW'(4));
        check(error_f && !busy && ncfg, "R1 bad mode", {error_f, busy, ncfg}, 3'b101);

        // R5: serial, LSB first
        load_bytes = '{8'hA5, 8'h3C};
        run_load(2'd0, 1'b1, 1'b0);
        repeat (6) @(negedge clk);
        check(success && !error_f, "R11 success held", {success, error_f}, 2'b10);

        // R6: parallel, with an ignored start in the middle
        load_bytes = '{8'h01, 8'hFE, 8'h80};
        run_load(2'd1, 1'b1, 1'b1);

        // R7: secure parallel
        load_bytes = '{8'h5A, 8'hC3};
        run_load(2'd2, 1'b1, 1'b0);

        // R10: completion line stays low
        load_bytes = '{8'h77};
        run_load(2'd1, 1'b0, 1'b0);

        // R9: status drops while the next byte is offered
        data_req = "R9";
        final_rises = 0;
        handshakes = 0;
        conf_done = 1'b1;
        feed_q.push_back(8'h9D);
        exp_q.push_back(8'h9D);
        pulse_start(2'd1, CW'(2));
        while (sent != CW'(1)) @(negedge clk);
        nstatus = 1'b0;
        feed_q.push_back(8'h42);
        wait_idle();
        repeat (3) @(negedge clk);
        check(error_f && !success, "R9 abort flags", {error_f, success}, 2'b10);
        check(sent == CW'(1), "R9 bytes recorded", sent, 1);
        check(feed_q.size() == 1 && handshakes == 1, "R9 byte not taken", feed_q.size(), 1);
        check(final_rises == 0 && exp_q.size() == 0, "R9 no extra edge", final_rises, 0);
        check(!dclk, "R9 dclk low", dclk, 0);
        feed_q.delete();
        exp_q.delete();
        nstatus = 1'b1;
        repeat (5) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule